// File: doc/BRIEF.md
# Nonvolatile Store and Recall Sequencer

This block sits between a system port and a pair of storage arrays: a working SRAM that serves normal reads and writes, and a shadow nonvolatile array that keeps a copy of it. It decides when a copy runs and in which direction. It times each copy and keeps the memory port closed while a copy is in flight.

A store copies the SRAM into the shadow array in two timed phases: first an erase, then a program. Three sources can start a store: a software command, a hardware request pin, and a digital power-fail input. The pin and the power-fail input only act when the SRAM has been written since the last completed store or recall. The software command always acts. A software command can also switch the power-fail trigger off and on. A recall, started only by a software command, copies the shadow array back into the SRAM. While any copy runs, the block raises a ready-bit style busy flag, pulls an active-low busy pin, and refuses memory accesses. After a store caused by power failure, the block stays busy until reset.

Top module: `nvs_seq`

## Requirements
- R1: In reset and on the first cycle after it, phase_o is 0 (idle), rdy_o is 0, busy_n_o is 1, mem_rdata_o is 0, the SRAM reads as all zero, nothing counts as written, and the power-fail trigger is enabled.
- R2: While idle, mem_gnt_o equals mem_req_i. A granted write (mem_we_i=1) stores mem_wdata_i at mem_addr_i. A granted read presents the addressed word on mem_rdata_o from the next cycle.
- R3: While phase_o is not 0, mem_gnt_o is 0, writes do not change the SRAM, and mem_rdata_o holds its value.
- R4: rdy_o is 1 and busy_n_o is 0 in every cycle where phase_o is not 0, and rdy_o is 0 and busy_n_o is 1 when phase_o is 0.
- R5: A store starts on the cycle after its trigger is sampled. phase_o shows 1 (erase) for exactly ERASE_CYC cycles and then 2 (program) for exactly PROG_CYC cycles. After that it returns to 0, or goes to 4 if the store came from power failure.
- R6: cmd_vld_i with cmd_i=3'd1 starts a store even when nothing has been written since the last store or recall.
- R7: hw_store_i and pwr_fail_i start a store only if a granted write has happened since the last completed store or recall. The written flag is the value held before the current cycle, so a write in the same cycle as the trigger does not count. Otherwise the trigger is ignored.
- R8: cmd_vld_i with cmd_i=3'd2 starts a recall. phase_o shows 3 for exactly RECALL_CYC cycles, after which the SRAM holds the shadow contents and the written flag is cleared.
- R9: A completed store leaves in the shadow array the SRAM image present at the end of the program phase, and clears the written flag.
- R10: cmd_i=3'd3 (with cmd_vld_i) turns the power-fail trigger off, and cmd_i=3'd4 turns it back on. While it is off, pwr_fail_i has no effect.
- R11: Triggers and commands that arrive while phase_o is not 0 are dropped, not queued.
- R12: When several triggers are valid in the same idle cycle, the winner follows this order: power fail first, then the hardware pin, then the software store, then recall.
- R13: After a power-fail store completes, phase_o stays 4 with busy shown until rst. The shadow contents survive that reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mem_req_i | input | 1 | Memory access request |
| mem_we_i | input | 1 | 1 = write, 0 = read |
| mem_addr_i | input | ADDR_W | Word address |
| mem_wdata_i | input | DATA_W | Write data |
| mem_gnt_o | output | 1 | Access accepted this cycle |
| mem_rdata_o | output | DATA_W | Read data, registered |
| cmd_vld_i | input | 1 | Command strobe |
| cmd_i | input | 3 | 1 store, 2 recall, 3 power-fail trigger off, 4 power-fail trigger on |
| hw_store_i | input | 1 | Hardware store request |
| pwr_fail_i | input | 1 | Power-fail indication |
| rdy_o | output | 1 | Busy status bit, 1 while copying |
| busy_n_o | output | 1 | Active-low busy pin |
| phase_o | output | 3 | 0 idle, 1 erase, 2 program, 3 recall, 4 locked |

## Verification
The case that needs care is a memory write that lands in the same idle cycle as a conditional store trigger. The bench writes a word while pulsing the hardware request on a clean array, and checks two things: the store is skipped, because the written flag is sampled before that write, and the word still lands in the SRAM. A second pulse on the next cycle must then start a store. The bench also drives a software store together with power failure, and a recall together with the hardware pin. For each it judges the winner from the phase sequence and the final locked or idle state.

// File: rtl/nvs_pkg.sv
package nvs_pkg;

    typedef enum logic [2:0] {
        PH_IDLE   = 3'd0,
        PH_ERASE  = 3'd1,
        PH_PROG   = 3'd2,
        PH_RECALL = 3'd3,
        PH_LOCK   = 3'd4
    } phase_e;

    localparam logic [2:0] CMD_STORE  = 3'd1;
    localparam logic [2:0] CMD_RECALL = 3'd2;
    localparam logic [2:0] CMD_AS_OFF = 3'd3;
    localparam logic [2:0] CMD_AS_ON  = 3'd4;

    typedef enum logic [2:0] {
        TRG_NONE,
        TRG_PWR,
        TRG_PIN,
        TRG_SW,
        TRG_RCL
    } trig_e;

    typedef struct packed {
        logic pwr;
        logic pin;
        logic sw;
        logic rcl;
    } req_t;

    function automatic trig_e pick_trigger(req_t r);
        if (r.pwr)      return TRG_PWR;
        else if (r.pin) return TRG_PIN;
        else if (r.sw)  return TRG_SW;
        else if (r.rcl) return TRG_RCL;
        return TRG_NONE;
    endfunction

    function automatic int max3(int a, int b, int c);
        int m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

endpackage

// File: rtl/nvs_arbiter.sv
module nvs_arbiter
    import nvs_pkg::*;
(
    input  logic       idle,
    input  logic       cmd_vld,
    input  logic [2:0] cmd,
    input  logic       hw_req,
    input  logic       pwr_fail,
    input  logic       dirty,
    input  logic       auto_en,
    output trig_e      trig,
    output logic       as_off,
    output logic       as_on
);
    req_t req;

    always_comb begin
        req.pwr = pwr_fail & auto_en & dirty;
        req.pin = hw_req & dirty;
        req.sw  = cmd_vld & (cmd == CMD_STORE);
        req.rcl = cmd_vld & (cmd == CMD_RECALL);
        trig    = idle ? pick_trigger(req) : TRG_NONE;
        as_off  = idle & cmd_vld & (cmd == CMD_AS_OFF);
        as_on   = idle & cmd_vld & (cmd == CMD_AS_ON);
    end
endmodule

// File: rtl/nvs_ctrl.sv
module nvs_ctrl
    import nvs_pkg::*;
#(
    parameter int ERASE_CYC  = 6,
    parameter int PROG_CYC   = 8,
    parameter int RECALL_CYC = 5
) (
    input  logic   clk,
    input  logic   rst,
    input  trig_e  trig,
    input  logic   as_off,
    input  logic   as_on,
    input  logic   wr_done,
    output phase_e phase,
    output logic   erase_done,
    output logic   prog_done,
    output logic   rcl_done,
    output logic   dirty,
    output logic   auto_en
);
    localparam int MAXC = max3(ERASE_CYC, PROG_CYC, RECALL_CYC);
    localparam int CW   = $clog2(MAXC + 1);

    logic [CW-1:0] cnt;
    logic          from_pwr;
    logic          last;

    assign last       = (cnt == '0);
    assign erase_done = (phase == PH_ERASE)  && last;
    assign prog_done  = (phase == PH_PROG)   && last;
    assign rcl_done   = (phase == PH_RECALL) && last;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase    <= PH_IDLE;
            cnt      <= '0;
            dirty    <= 1'b0;
            auto_en  <= 1'b1;
            from_pwr <= 1'b0;
        end else begin
            case (phase)
                PH_IDLE: begin
                    if (wr_done) dirty <= 1'b1;
                    if (as_off)  auto_en <= 1'b0;
                    if (as_on)   auto_en <= 1'b1;
                    if (trig == TRG_RCL) begin
                        phase <= PH_RECALL;
                        cnt   <= CW'(RECALL_CYC - 1);
                    end else if (trig != TRG_NONE) begin
                        phase    <= PH_ERASE;
                        cnt      <= CW'(ERASE_CYC - 1);
                        from_pwr <= (trig == TRG_PWR);
                    end
                end
                PH_ERASE: begin
                    if (last) begin
                        phase <= PH_PROG;
                        cnt   <= CW'(PROG_CYC - 1);
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                PH_PROG: begin
                    if (last) begin
                        phase <= from_pwr ? PH_LOCK : PH_IDLE;
                        dirty <= 1'b0;
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                PH_RECALL: begin
                    if (last) begin
                        phase <= PH_IDLE;
                        dirty <= 1'b0;
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                default: phase <= PH_LOCK;
            endcase
        end
    end
endmodule

// File: rtl/nvs_arrays.sv
module nvs_arrays #(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              acc,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              erase_done,
    input  logic              prog_done,
    input  logic              rcl_done,
    output logic [DATA_W-1:0] rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] sram [DEPTH];
    logic [DATA_W-1:0] shadow [DEPTH];

    always_ff @(posedge clk) begin
        for (int i = 0; i < DEPTH; i++) begin
            if (rst)
                sram[i] <= '0;
            else if (rcl_done)
                sram[i] <= shadow[i];
            else if (acc && we && addr == ADDR_W'(i))
                sram[i] <= wdata;
        end
    end

    always_ff @(posedge clk) begin
        for (int i = 0; i < DEPTH; i++) begin
            if (erase_done)
                shadow[i] <= '0;
            else if (prog_done)
                shadow[i] <= sram[i];
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            rdata <= '0;
        else if (acc && !we)
            rdata <= sram[addr];
    end
endmodule

// File: rtl/nvs_seq.sv
module nvs_seq
    import nvs_pkg::*;
#(
    parameter int ADDR_W     = 4,
    parameter int DATA_W     = 8,
    parameter int ERASE_CYC  = 6,
    parameter int PROG_CYC   = 8,
    parameter int RECALL_CYC = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              mem_req_i,
    input  logic              mem_we_i,
    input  logic [ADDR_W-1:0] mem_addr_i,
    input  logic [DATA_W-1:0] mem_wdata_i,
    output logic              mem_gnt_o,
    output logic [DATA_W-1:0] mem_rdata_o,
    input  logic              cmd_vld_i,
    input  logic [2:0]        cmd_i,
    input  logic              hw_store_i,
    input  logic              pwr_fail_i,
    output logic              rdy_o,
    output logic              busy_n_o,
    output logic [2:0]        phase_o
);
    phase_e phase;
    trig_e  trig;
    logic   idle, as_off, as_on, dirty_q, auto_en;
    logic   erase_done, prog_done, rcl_done;

    assign idle      = (phase == PH_IDLE);
    assign mem_gnt_o = mem_req_i & idle;
    assign rdy_o     = ~idle;
    assign busy_n_o  = idle;
    assign phase_o   = phase;

    nvs_arbiter u_arb (
        .idle     (idle),
        .cmd_vld  (cmd_vld_i),
        .cmd      (cmd_i),
        .hw_req   (hw_store_i),
        .pwr_fail (pwr_fail_i),
        .dirty    (dirty_q),
        .auto_en  (auto_en),
        .trig     (trig),
        .as_off   (as_off),
        .as_on    (as_on)
    );

    nvs_ctrl #(
        .ERASE_CYC  (ERASE_CYC),
        .PROG_CYC   (PROG_CYC),
        .RECALL_CYC (RECALL_CYC)
    ) u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .trig       (trig),
        .as_off     (as_off),
        .as_on      (as_on),
        .wr_done    (mem_gnt_o & mem_we_i),
        .phase      (phase),
        .erase_done (erase_done),
        .prog_done  (prog_done),
        .rcl_done   (rcl_done),
        .dirty      (dirty_q),
        .auto_en    (auto_en)
    );

    nvs_arrays #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_mem (
        .clk        (clk),
        .rst        (rst),
        .acc        (mem_gnt_o),
        .we         (mem_we_i),
        .addr       (mem_addr_i),
        .wdata      (mem_wdata_i),
        .erase_done (erase_done),
        .prog_done  (prog_done),
        .rcl_done   (rcl_done),
        .rdata      (mem_rdata_o)
    );
endmodule

// File: rtl/nvs_seq_chk.sv
module nvs_seq_chk #(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst,
    input logic [2:0]        phase,
    input logic              rdy,
    input logic              gnt,
    input logic [DATA_W-1:0] rdata,
    input logic              dirty
);
    assert_no_grant_busy_R3: assert property (@(posedge clk) disable iff (rst)
        rdy |-> !gnt);

    assert_rdata_hold_R3: assert property (@(posedge clk) disable iff (rst)
        rdy |=> $stable(rdata));

    assert_start_phase_R5: assert property (@(posedge clk) disable iff (rst)
        $rose(rdy) |-> (phase == 3'd1 || phase == 3'd3));

    assert_erase_next_R5: assert property (@(posedge clk) disable iff (rst)
        (phase == 3'd1) |=> (phase == 3'd1 || phase == 3'd2));

    assert_prog_next_R5: assert property (@(posedge clk) disable iff (rst)
        (phase == 3'd2) |=> (phase == 3'd2 || phase == 3'd0 || phase == 3'd4));

    assert_recall_next_R8: assert property (@(posedge clk) disable iff (rst)
        (phase == 3'd3) |=> (phase == 3'd3 || phase == 3'd0));

    assert_clean_after_copy_R9: assert property (@(posedge clk) disable iff (rst)
        $fell(rdy) |-> !dirty);

    assert_lock_holds_R13: assert property (@(posedge clk) disable iff (rst)
        (phase == 3'd4) |=> (phase == 3'd4 && rdy));
endmodule

bind nvs_seq nvs_seq_chk #(.DATA_W(DATA_W)) u_chk (
    .clk   (clk),
    .rst   (rst),
    .phase (phase_o),
    .rdy   (rdy_o),
    .gnt   (mem_gnt_o),
    .rdata (mem_rdata_o),
    .dirty (dirty_q)
);

// File: tb/nvs_seq_test.sv
module nvs_seq_test;
    localparam int AW = 4, DW = 8, NE = 6, NP = 8, NR = 5;
    localparam int DEPTH = 1 << AW;

    logic clk = 0, rst = 1;
    logic req = 0, we = 0, cvld = 0, hw = 0, pf = 0;
    logic [AW-1:0] addr = '0;
    logic [DW-1:0] wdata = '0;
    logic [2:0] cmd = '0;
    logic gnt, rdy, busy_n;
    logic [DW-1:0] rdata;
    logic [2:0] phase;

    int n_chk = 0, n_fail = 0;
    logic [DW-1:0] exp_mem [DEPTH];

    always #4 clk = ~clk;

    nvs_seq #(.ADDR_W(AW), .DATA_W(DW), .ERASE_CYC(NE), .PROG_CYC(NP),
              .RECALL_CYC(NR)) uut (
        .clk(clk), .rst(rst), .mem_req_i(req), .mem_we_i(we),
        .mem_addr_i(addr), .mem_wdata_i(wdata), .mem_gnt_o(gnt),
        .mem_rdata_o(rdata), .cmd_vld_i(cvld), .cmd_i(cmd),
        .hw_store_i(hw), .pwr_fail_i(pf), .rdy_o(rdy),
        .busy_n_o(busy_n), .phase_o(phase));

    task automatic check(string tag, int act, int exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1; req = 0; cvld = 0; hw = 0; pf = 0;
        repeat (3) @(negedge clk);
        rst = 0;
    endtask

    task automatic wr(input int a, input int d);
        @(negedge clk);
        req = 1; we = 1; addr = AW'(a); wdata = DW'(d);
        #1 check("R2 write grant", gnt, 1);
        @(negedge clk);
        req = 0; we = 0;
    endtask

    task automatic rd_check(input int a, input int d, input string tag);
        @(negedge clk);
        req = 1; we = 0; addr = AW'(a);
        @(negedge clk);
        req = 0;
        check(tag, rdata, d);
    endtask

    task automatic pulse(input logic c_v, input logic [2:0] c, input logic h, input logic p);
        @(negedge clk);
        cvld = c_v; cmd = c; hw = h; pf = p;
        @(negedge clk);
        cvld = 0; hw = 0; pf = 0;
    endtask

    task automatic run_busy(output int ne, output int np, output int nr,
                            output int endph, output int bad);
        int guard = 0;
        ne = 0; np = 0; nr = 0; bad = 0;
        while ((phase == 3'd1 || phase == 3'd2 || phase == 3'd3) && guard < 100) begin
            if (phase == 3'd1) begin ne++; if (np != 0) bad = 1; end
            if (phase == 3'd2) np++;
            if (phase == 3'd3) nr++;
            if (rdy !== 1'b1 || busy_n !== 1'b0) bad = 1;
            @(negedge clk);
            guard++;
        end
        endph = phase;
    endtask

    task automatic t_reset();
        do_reset();
        check("R1 phase", phase, 0);
        check("R1 rdy", rdy, 0);
        check("R1 busy_n", busy_n, 1);
        check("R1 rdata", rdata, 0);
        rd_check(9, 0, "R1 sram cleared");
    endtask

    task automatic t_sw_clean();
        int ne, np, nr, ep, bad;
        pulse(1, 3'd1, 0, 0);
        check("R6 sw store starts clean", phase, 1);
        run_busy(ne, np, nr, ep, bad);
        check("R5 erase span", ne, NE);
        check("R5 prog span", np, NP);
        check("R4 busy pins", bad, 0);
        check("R5 back to idle", ep, 0);
        check("R4 idle rdy", rdy, 0);
    endtask

    task automatic t_clean_ignored();
        pulse(0, 0, 1, 0);
        check("R7 pin ignored clean", phase, 0);
        pulse(0, 0, 0, 1);
        check("R7 pwr ignored clean", phase, 0);
    endtask

    task automatic t_rw();
        for (int i = 0; i < DEPTH; i++) begin
            wr(i, 8'hA0 + i);
            exp_mem[i] = DW'(8'hA0 + i);
        end
        rd_check(0, 8'hA0, "R2 read 0");
        rd_check(15, 8'hAF, "R2 read 15");
        rd_check(6, 8'hA6, "R2 read 6");
    endtask

    task automatic t_pin_store();
        int ne, np, nr, ep, bad;
        logic [DW-1:0] rd_before;
        rd_before = rdata;
        pulse(0, 0, 1, 0);
        check("R7 pin store dirty", phase, 1);
        req = 1; we = 1; addr = '0; wdata = 8'hFF; cvld = 1; cmd = 3'd2;
        #1 check("R3 no grant busy", gnt, 0);
        @(negedge clk);
        req = 0; we = 0; cvld = 0;
        check("R3 rdata held", rdata, rd_before);
        run_busy(ne, np, nr, ep, bad);
        check("R5 erase span after probe", ne, NE - 1);
        check("R5 prog span pin", np, NP);
        check("R5 pin store idle", ep, 0);
        @(negedge clk);
        check("R11 recall dropped", phase, 0);
        pulse(0, 0, 1, 0);
        check("R9 store cleared written", phase, 0);
    endtask

    task automatic t_recall();
        int ne, np, nr, ep, bad;
        for (int i = 0; i < DEPTH; i++) wr(i, 8'h50 + i);
        rd_check(4, 8'h54, "R2 overwrite");
        pulse(1, 3'd2, 0, 0);
        check("R8 recall phase", phase, 3);
        run_busy(ne, np, nr, ep, bad);
        check("R8 recall span", nr, NR);
        check("R8 recall idle", ep, 0);
        rd_check(0, 8'hA0, "R3 busy write dropped");
        rd_check(4, 8'hA4, "R8 recalled word 4");
        rd_check(12, 8'hAC, "R8 recalled word 12");
        pulse(0, 0, 1, 0);
        check("R8 recall cleared written", phase, 0);
    endtask

    task automatic t_autostore_off();
        pulse(1, 3'd3, 0, 0);
        wr(3, 8'h33); exp_mem[3] = 8'h33;
        @(negedge clk); pf = 1;
        repeat (3) @(negedge clk);
        check("R10 pwr ignored when off", phase, 0);
        pf = 0;
    endtask

    task automatic t_priority_and_race();
        int ne, np, nr, ep, bad;
        pulse(1, 3'd2, 1, 0);
        check("R12 pin beats recall", phase, 1);
        run_busy(ne, np, nr, ep, bad);
        check("R12 no recall cycles", nr, 0);
        check("R12 store ended idle", ep, 0);
        @(negedge clk);
        req = 1; we = 1; addr = 4'd5; wdata = 8'h55; hw = 1;
        exp_mem[5] = 8'h55;
        @(negedge clk);
        req = 0; we = 0; hw = 0;
        check("R7 same-cycle write not counted", phase, 0);
        rd_check(5, 8'h55, "R7 racing write kept");
        pulse(0, 0, 1, 0);
        check("R7 pin after write", phase, 1);
        run_busy(ne, np, nr, ep, bad);
        check("R5 pin store total", ne + np, NE + NP);
    endtask

    task automatic t_pwr_lock();
        int ne, np, nr, ep, bad;
        wr(7, 8'h77); exp_mem[7] = 8'h77;
        pulse(1, 3'd4, 0, 0);
        pulse(1, 3'd1, 0, 1);
        check("R10 pwr on again", phase, 1);
        run_busy(ne, np, nr, ep, bad);
        check("R12 pwr beats sw (lock)", ep, 4);
        check("R5 pwr store spans", ne * 100 + np, NE * 100 + NP);
        repeat (20) @(negedge clk);
        req = 1; we = 0;
        #1;
        check("R13 still locked", phase, 4);
        check("R13 busy pin low", busy_n, 0);
        check("R13 no grant locked", gnt, 0);
        req = 0;
        do_reset();
        check("R13 reset leaves lock", phase, 0);
        rd_check(7, 0, "R1 sram cleared by reset");
        pulse(1, 3'd2, 0, 0);
        run_busy(ne, np, nr, ep, bad);
        check("R8 recall after reset", nr, NR);
        rd_check(3, 8'h33, "R13 shadow kept word 3");
        rd_check(5, 8'h55, "R13 shadow kept word 5");
        rd_check(7, 8'h77, "R13 shadow kept word 7");
        rd_check(0, 8'hA0, "R9 image word 0");
    endtask

    initial begin
        t_reset();
        t_sw_clean();
        t_clean_ignored();
        t_rw();
        t_pin_store();
        t_recall();
        t_autostore_off();
        t_priority_and_race();
        t_pwr_lock();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule